// File: doc/BRIEF.md
# SPI Slave Idle and Wake-Up Controller

This block is the power-management front of a multichannel SPI peripheral. The system power manager raises an idle request. The block waits until no SPI word is in flight, then acknowledges and enters wake-up mode. The configured clock-activity field states which clocks may be removed, and clock removal is only granted when the peripheral is an SPI slave. In wake-up mode the interrupt and DMA request lines are forced low, register accesses get an error response, and one SPI word may still complete. The block notes that a word finished and holds that note until software reads the word after the clocks return.

Wake-up is armed when four things hold together: the global wake-up enable is set, the per-source wake enable is set, channel 0 is enabled and the peripheral is a slave. When armed and in wake-up mode, an asserted channel-0 chip select drives the wake request straight from the pin, with no clock in the path. A two-flop synchronised copy sets a sticky flag, so the request stays up after the select is released. The request drops when the power manager removes its idle request. On the way back to normal mode the recorded event sets a write-one-to-clear status bit. When its interrupt enable is set, that bit also drives the interrupt line.

The state machine has four states. ST_RUN is normal operation. ST_IDLE_WAIT has seen the idle request and waits for the bus to be quiet. ST_WAKE is wake-up mode and holds the acknowledge. ST_EXIT lasts one cycle and records the wake event. The transitions are:
- ST_RUN to ST_IDLE_WAIT when the idle request is seen.
- ST_IDLE_WAIT back to ST_RUN when the request is withdrawn.
- ST_IDLE_WAIT to ST_WAKE when the request is still high and no transfer is busy.
- ST_WAKE to ST_EXIT when the request falls.
- ST_EXIT to ST_RUN unconditionally.

Top module: `spiw_idle_ctrl`

## Requirements
- R1: After reset `idle_ack`, `wake_req`, `sts_wks`, `irq`, `dma_req`, `word_pend` and `clk_cut_ok` are all 0.
- R2: With `xfer_busy` low, `idle_ack` rises at the second rising clock edge after `idle_req` goes high. While `xfer_busy` is high, `idle_ack` stays low. It rises at the first edge after `xfer_busy` falls, provided `idle_req` is still high.
- R3: `idle_ack` falls at the first edge after `idle_req` falls. If `idle_req` is withdrawn before the acknowledge, `idle_ack` never rises.
- R4: `wake_req` is 1 only while `idle_ack` is 1, `cfg_slave`, `cfg_ena_wakeup`, `cfg_wken` and `ch0_en` are all 1, and either `cs0_n` is low (active-low select) or a select was already recorded in this wake-up period. The raw pin acts on `wake_req` in the same cycle, without a clock edge.
- R5: Once `cs0_n` has been low for three rising edges in an armed wake-up period, `wake_req` stays 1 after `cs0_n` returns high, until `idle_ack` falls.
- R6: While `idle_ack` is 1, `irq` and `dma_req` are 0 whatever `core_irq`, `core_dma` and the status bit hold. Outside wake-up mode `dma_req` follows `core_dma`, and `irq` is `core_irq` OR (`sts_wks` AND `wke_en`).
- R7: `reg_err` equals `reg_access` while `idle_ack` is 1, and is 0 otherwise.
- R8: `clk_cut_ok` equals `cfg_clk_activity` while `idle_ack` is 1 and `cfg_slave` is 1, and is 2'b00 otherwise. Bit 0 allows the interface clock to be cut and bit 1 the functional clock, so 2'b11 allows both.
- R9: If a wake select was recorded, `sts_wks` is 1 at the second edge after `idle_req` falls. If none was recorded, `sts_wks` is unchanged.
- R10: A high `sts_clr_wks` at an edge clears `sts_wks`, unless a wake event is recorded at the same edge, in which case `sts_wks` is 1.
- R11: A `word_done` pulse in a slave wake-up period sets `word_pend`. `word_read` has no effect on it in wake-up mode. A `word_read` outside wake-up mode clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface/functional clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_slave | input | 1 | 1 = peripheral is an SPI slave |
| cfg_ena_wakeup | input | 1 | Global wake-up enable |
| cfg_wken | input | 1 | Per-source wake enable |
| cfg_clk_activity | input | 2 | Clocks allowed off in idle (bit0 interface, bit1 functional) |
| ch0_en | input | 1 | Channel 0 enabled |
| wke_en | input | 1 | Interrupt enable for the wake status bit |
| cs0_n | input | 1 | Channel 0 chip select, active low, asynchronous |
| idle_req | input | 1 | Idle request from the power manager |
| idle_ack | output | 1 | Idle acknowledge; high in wake-up mode |
| wake_req | output | 1 | Wake request to the power manager |
| clk_cut_ok | output | 2 | Clocks the power manager may remove |
| xfer_busy | input | 1 | An SPI word is being shifted |
| word_done | input | 1 | An SPI word completed |
| word_read | input | 1 | Software read the received word |
| word_pend | output | 1 | A word finished in wake-up mode and is unread |
| core_irq | input | 1 | Raw interrupt from the peripheral core |
| core_dma | input | 1 | Raw DMA request from the peripheral core |
| irq | output | 1 | Gated interrupt request |
| dma_req | output | 1 | Gated DMA request |
| reg_access | input | 1 | A register access is in progress |
| reg_err | output | 1 | Error response for that access |
| sts_clr_wks | input | 1 | Write-one-to-clear strobe for the wake status |
| sts_wks | output | 1 | Wake event status |

## Verification
The table sweeps every arming input on its own. A design that dropped one enable term, or ignored slave mode, would raise `wake_req` and `sts_wks` on rows where they must stay low. A busy transfer is held across the acknowledge point to catch an acknowledge that ignores the in-flight word. The idle request is also withdrawn during the wait state, which exposes a machine that acknowledges anyway. A software clear is driven in the same cycle as a fresh wake event, so reversing that priority loses the status bit. Register accesses and `word_read` are driven inside wake-up mode, which shows an error response that is never given or a pending word dropped too early. The select is released before the request ends, which catches a wake request that is not latched.

// File: rtl/spiw_pkg.sv
package spiw_pkg;

    typedef enum logic [1:0] {
        ST_RUN       = 2'd0,
        ST_IDLE_WAIT = 2'd1,
        ST_WAKE      = 2'd2,
        ST_EXIT      = 2'd3
    } spiw_state_e;

endpackage

// File: rtl/spiw_cs_sync.sv
module spiw_cs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_n_async,
    output logic cs_act_sync
);

    localparam int LAST = STAGES - 1;

    logic [LAST:0] chain_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= cs_n_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain_q <= '1;
                else        chain_q <= {chain_q[LAST-1:0], cs_n_async};
            end
        end
    endgenerate

    assign cs_act_sync = ~chain_q[LAST];

endmodule

// File: rtl/spiw_fsm.sv
module spiw_fsm
    import spiw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic idle_req,
    input  logic xfer_busy,
    input  logic wake_arm,
    input  logic cs_act_raw,
    input  logic cs_act_sync,
    output logic in_wake,
    output logic wake_req,
    output logic wake_set
);

    spiw_state_e state_q, state_d;
    logic        seen_q, seen_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:       if (idle_req) state_d = ST_IDLE_WAIT;
            ST_IDLE_WAIT: begin
                if (!idle_req)      state_d = ST_RUN;
                else if (!xfer_busy) state_d = ST_WAKE;
            end
            ST_WAKE:      if (!idle_req) state_d = ST_EXIT;
            ST_EXIT:      state_d = ST_RUN;
            default:      state_d = ST_RUN;
        endcase
    end

    always_comb begin
        seen_d = seen_q;
        if (state_q == ST_WAKE && wake_arm && cs_act_sync) seen_d = 1'b1;
        else if (state_q == ST_EXIT)                        seen_d = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
            seen_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            seen_q  <= seen_d;
        end
    end

    always_comb begin
        in_wake  = 1'b0;
        wake_set = 1'b0;
        unique case (state_q)
            ST_RUN, ST_IDLE_WAIT: ;
            ST_WAKE:  in_wake  = 1'b1;
            ST_EXIT:  wake_set = seen_q;
            default:  ;
        endcase
        wake_req = in_wake && (seen_q || (wake_arm && cs_act_raw));
    end

    AST_ACK_AFTER_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_wake) |-> $past(idle_req) && !$past(xfer_busy)); // R2
    AST_LEAVE_ON_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_wake) |-> !$past(idle_req)); // R3
    AST_WAKE_NEEDS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        wake_req |-> in_wake); // R4

endmodule

// File: rtl/spiw_status.sv
module spiw_status (
    input  logic clk,
    input  logic rst_n,
    input  logic in_wake,
    input  logic cfg_slave,
    input  logic wake_set,
    input  logic wks_clr,
    input  logic wke_en,
    input  logic core_irq,
    input  logic core_dma,
    input  logic word_done,
    input  logic word_read,
    output logic sts_wks,
    output logic word_pend,
    output logic irq,
    output logic dma_req
);

    logic wks_q, pend_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wks_q  <= 1'b0;
            pend_q <= 1'b0;
        end else begin
            if (wake_set)     wks_q <= 1'b1;
            else if (wks_clr) wks_q <= 1'b0;

            if (in_wake && cfg_slave && word_done) pend_q <= 1'b1;
            else if (!in_wake && word_read)        pend_q <= 1'b0;
        end
    end

    always_comb begin
        sts_wks   = wks_q;
        word_pend = pend_q;
        irq       = !in_wake && (core_irq || (wks_q && wke_en));
        dma_req   = !in_wake && core_dma;
    end

    AST_SET_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        wake_set |=> sts_wks); // R10
    AST_CLEAR_WORKS: assert property (@(posedge clk) disable iff (!rst_n)
        (wks_clr && !wake_set) |=> !sts_wks); // R10
    AST_PEND_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_wake && word_pend) |=> word_pend); // R11

endmodule

// File: rtl/spiw_idle_ctrl.sv
module spiw_idle_ctrl #(
    parameter int SYNC_STAGES = 2,
    parameter int CLK_SEL_W   = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_slave,
    input  logic                 cfg_ena_wakeup,
    input  logic                 cfg_wken,
    input  logic [CLK_SEL_W-1:0] cfg_clk_activity,
    input  logic                 ch0_en,
    input  logic                 wke_en,
    input  logic                 cs0_n,
    input  logic                 idle_req,
    output logic                 idle_ack,
    output logic                 wake_req,
    output logic [CLK_SEL_W-1:0] clk_cut_ok,
    input  logic                 xfer_busy,
    input  logic                 word_done,
    input  logic                 word_read,
    output logic                 word_pend,
    input  logic                 core_irq,
    input  logic                 core_dma,
    output logic                 irq,
    output logic                 dma_req,
    input  logic                 reg_access,
    output logic                 reg_err,
    input  logic                 sts_clr_wks,
    output logic                 sts_wks
);

    logic cs_act_sync;
    logic in_wake;
    logic wake_set;
    logic wake_arm;

    assign wake_arm = cfg_slave && cfg_ena_wakeup && cfg_wken && ch0_en;

    spiw_cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk         (clk),
        .rst_n       (rst_n),
        .cs_n_async  (cs0_n),
        .cs_act_sync (cs_act_sync)
    );

    spiw_fsm u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .idle_req    (idle_req),
        .xfer_busy   (xfer_busy),
        .wake_arm    (wake_arm),
        .cs_act_raw  (~cs0_n),
        .cs_act_sync (cs_act_sync),
        .in_wake     (in_wake),
        .wake_req    (wake_req),
        .wake_set    (wake_set)
    );

    spiw_status u_status (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_wake   (in_wake),
        .cfg_slave (cfg_slave),
        .wake_set  (wake_set),
        .wks_clr   (sts_clr_wks),
        .wke_en    (wke_en),
        .core_irq  (core_irq),
        .core_dma  (core_dma),
        .word_done (word_done),
        .word_read (word_read),
        .sts_wks   (sts_wks),
        .word_pend (word_pend),
        .irq       (irq),
        .dma_req   (dma_req)
    );

    assign idle_ack   = in_wake;
    assign reg_err    = in_wake && reg_access;
    assign clk_cut_ok = (in_wake && cfg_slave) ? cfg_clk_activity : '0;

    AST_NO_WAKE_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_slave |-> !wake_req); // R4
    AST_LINES_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        idle_ack |-> (!irq && !dma_req)); // R6
    AST_ERR_IN_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack && reg_access) |-> reg_err); // R7
    AST_CUT_MASTER: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_slave |-> (clk_cut_ok == '0)); // R8

endmodule

// File: tb/spiw_idle_ctrl_bench.sv
module spiw_idle_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_slave = 1'b0, cfg_ena_wakeup = 1'b0, cfg_wken = 1'b0;
    logic [1:0] cfg_clk_activity = 2'b00;
    logic       ch0_en = 1'b0, wke_en = 1'b0, cs0_n = 1'b1, idle_req = 1'b0;
    logic       xfer_busy = 1'b0, word_done = 1'b0, word_read = 1'b0;
    logic       core_irq = 1'b0, core_dma = 1'b0, reg_access = 1'b0, sts_clr_wks = 1'b0;
    logic       idle_ack, wake_req, word_pend, irq, dma_req, reg_err, sts_wks;
    logic [1:0] clk_cut_ok;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    spiw_idle_ctrl u_spiw_idle_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_slave(cfg_slave), .cfg_ena_wakeup(cfg_ena_wakeup),
        .cfg_wken(cfg_wken), .cfg_clk_activity(cfg_clk_activity), .ch0_en(ch0_en),
        .wke_en(wke_en), .cs0_n(cs0_n), .idle_req(idle_req), .idle_ack(idle_ack),
        .wake_req(wake_req), .clk_cut_ok(clk_cut_ok), .xfer_busy(xfer_busy),
        .word_done(word_done), .word_read(word_read), .word_pend(word_pend),
        .core_irq(core_irq), .core_dma(core_dma), .irq(irq), .dma_req(dma_req),
        .reg_access(reg_access), .reg_err(reg_err), .sts_clr_wks(sts_clr_wks),
        .sts_wks(sts_wks)
    );

    // bit4 slave, bit3 global wake enable, bit2 wake enable, bit1 ch0 enable, bit0 expected wake
    localparam logic [4:0] TBL [8] = '{
        5'b11111, 5'b01110, 5'b10110, 5'b11010,
        5'b11100, 5'b00000, 5'b01000, 5'b11111
    };

    task automatic tick();
        @(posedge clk);
        #5;
    endtask

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic enter_wake();
        idle_req = 1'b1;
        tick();
        tick();
    endtask

    task automatic leave_wake();
        idle_req = 1'b0;
        tick();
        tick();
    endtask

    task automatic wake_event();
        enter_wake();
        cs0_n = 1'b0;
        repeat (4) tick();
        cs0_n = 1'b1;
    endtask

    initial begin
        #(20 * 150000);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) tick();
        // R1 reset values
        chk(idle_ack == 0 && wake_req == 0 && sts_wks == 0, "R1", idle_ack + wake_req + sts_wks, 0);
        chk(irq == 0 && dma_req == 0 && word_pend == 0 && clk_cut_ok == 0, "R1",
            irq + dma_req + word_pend + clk_cut_ok, 0);
        rst_n = 1'b1;
        tick();

        for (int i = 0; i < 8; i++) begin
            logic [4:0] v;
            v = TBL[i];
            {cfg_slave, cfg_ena_wakeup, cfg_wken, ch0_en} = v[4:1];
            cfg_clk_activity = 2'(i);
            idle_req = 1'b1;
            tick();
            chk(idle_ack == 0, "R2", idle_ack, 0);
            tick();
            chk(idle_ack == 1, "R2", idle_ack, 1);
            chk(clk_cut_ok == (v[4] ? 2'(i) : 2'b00), "R8", clk_cut_ok, v[4] ? i % 4 : 0);
            cs0_n = 1'b0;
            #1;
            chk(wake_req == v[0], "R4", wake_req, v[0]);
            repeat (4) tick();
            cs0_n = 1'b1;
            #1;
            chk(wake_req == v[0], "R5", wake_req, v[0]);
            idle_req = 1'b0;
            tick();
            chk(idle_ack == 0 && wake_req == 0, "R3", idle_ack + wake_req, 0);
            tick();
            chk(sts_wks == v[0], "R9", sts_wks, v[0]);
            chk(irq == 0, "R6", irq, 0);
            sts_clr_wks = 1'b1;
            tick();
            sts_clr_wks = 1'b0;
            chk(sts_wks == 0, "R10", sts_wks, 0);
        end

        // R2 busy transfer holds off the acknowledge
        {cfg_slave, cfg_ena_wakeup, cfg_wken, ch0_en} = 4'b1111;
        cfg_clk_activity = 2'b11;
        xfer_busy = 1'b1;
        idle_req = 1'b1;
        repeat (3) tick();
        chk(idle_ack == 0, "R2", idle_ack, 0);
        xfer_busy = 1'b0;
        tick();
        chk(idle_ack == 1, "R2", idle_ack, 1);

        // R6 R7 R8 R11 inside wake-up mode
        core_irq = 1'b1;
        core_dma = 1'b1;
        reg_access = 1'b1;
        #1;
        chk(irq == 0 && dma_req == 0, "R6", irq + dma_req, 0);
        chk(reg_err == 1, "R7", reg_err, 1);
        chk(clk_cut_ok == 2'b11, "R8", clk_cut_ok, 3);
        reg_access = 1'b0;
        word_done = 1'b1;
        tick();
        word_done = 1'b0;
        chk(word_pend == 1, "R11", word_pend, 1);
        word_read = 1'b1;
        tick();
        word_read = 1'b0;
        chk(word_pend == 1, "R11", word_pend, 1);
        leave_wake();
        chk(irq == 1 && dma_req == 1, "R6", irq + dma_req, 2);
        reg_access = 1'b1;
        #1;
        chk(reg_err == 0, "R7", reg_err, 0);
        reg_access = 1'b0;
        core_irq = 1'b0;
        core_dma = 1'b0;
        word_read = 1'b1;
        tick();
        word_read = 1'b0;
        chk(word_pend == 0, "R11", word_pend, 0);

        // R3 withdraw during the wait state
        idle_req = 1'b1;
        tick();
        idle_req = 1'b0;
        tick();
        chk(idle_ack == 0, "R3", idle_ack, 0);
        tick();
        chk(idle_ack == 0, "R3", idle_ack, 0);

        // R4 R8 master mode
        cfg_slave = 1'b0;
        enter_wake();
        cs0_n = 1'b0;
        repeat (4) tick();
        chk(wake_req == 0, "R4", wake_req, 0);
        chk(clk_cut_ok == 0, "R8", clk_cut_ok, 0);
        cs0_n = 1'b1;
        leave_wake();
        chk(sts_wks == 0, "R9", sts_wks, 0);

        // R9 interrupt from the wake status, R10 priority
        cfg_slave = 1'b1;
        wke_en = 1'b1;
        wake_event();
        leave_wake();
        chk(sts_wks == 1 && irq == 1, "R9", sts_wks + irq, 2);
        wake_event();
        idle_req = 1'b0;
        tick();
        sts_clr_wks = 1'b1;
        tick();
        sts_clr_wks = 1'b0;
        chk(sts_wks == 1, "R10", sts_wks, 1);
        sts_clr_wks = 1'b1;
        tick();
        sts_clr_wks = 1'b0;
        chk(sts_wks == 0 && irq == 0, "R10", sts_wks + irq, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule